// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave side of a four-wire serial configuration link. A host frames each access with an active-low select, clocks a 16-bit command word into the block, and then moves one to four data bytes. The command carries a read flag, a byte-count field and a 13-bit start address. Written bytes are handed to an external byte-wide buffer array through a one-cycle write strobe. Read bytes are fetched from that same buffer through a combinational read port and shifted back to the host.

The port keeps two mode bits of its own. They are loaded whenever a byte is written to the mode address, so the stored copy also lands in the buffer. One bit flips the bit order of the whole frame, command word included. The same bit reverses the direction in which the address moves from one byte to the next. The other bit moves read data from the dedicated serial output pin onto the shared data pin.

The serial pins are sampled with the block's fast system clock. The serial clock must therefore stay high and low for at least three system clocks per phase.

Top module: `scp_regport`

## Requirements
- R1: After reset no output driver is enabled, no write strobe is issued, and the port is in most-significant-bit-first, unidirectional mode.
- R2: The command word is 16 bits: bit 15 is the read flag (1 = read), bits 14:13 the byte-count code, bits 12:0 the start address. In MSB-first mode bit 15 is sent first.
- R3: Count code 00, 01, 10, 11 moves exactly 1, 2, 3, 4 data bytes; after the last byte the port is ready for a new command word within the same frame.
- R4: A written byte produces a single one-cycle `buf_wr_en` pulse, issued only after all 8 of its bits have been clocked in.
- R5: In MSB-first mode data bits go most significant first, and the byte address decrements after each byte, wrapping from 0000h to 1FFFh.
- R6: In LSB-first mode command and data bits go least significant first, so the read flag arrives last, and the byte address increments after each byte, wrapping from 1FFFh to 0000h.
- R7: Writing a byte to address 0000h loads the mode bits: bit 6 = 1 selects LSB-first, bit 7 = 1 selects bidirectional. The new order applies to the next frame without any further command.
- R8: On a read, the first data bit is present after the rising serial clock edge that completes the command word, and each later bit after the next rising edge. Each bit is therefore valid at the falling edge that follows. The byte comes from the buffer at the current address.
- R9: During read data, `sdo_oe` is high in unidirectional mode and `sdio_oe` is high in bidirectional mode; the other enable stays low, and both are low during commands and writes.
- R10: Raising `csb` aborts the access. Both enables drop, a partly received byte is discarded and not written, and the next frame starts with a command word.
- R11: `buf_rd_addr` presents the current byte address, so a multibyte read returns the bytes at the successive stepped addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| csb | input | 1 | Active-low frame select |
| sdio_in | input | 1 | Input side of the shared data pin |
| sdio_out | output | 1 | Read data for the shared data pin |
| sdio_oe | output | 1 | Drive enable of the shared data pin |
| sdo | output | 1 | Read data for the dedicated output pin |
| sdo_oe | output | 1 | Drive enable of the dedicated output pin |
| buf_wr_en | output | 1 | One-cycle byte write strobe to the buffer |
| buf_wr_addr | output | ADDR_W | Byte address of the write |
| buf_wr_data | output | 8 | Byte being written |
| buf_rd_addr | output | ADDR_W | Byte address being read |
| buf_rd_data | input | 8 | Buffer byte at `buf_rd_addr` |

## Verification
A rising edge on the `sclk` pin is acted on at the second system clock edge after it, because of one synchronizer stage and one edge register. Write strobes and output-enable changes therefore appear two cycles after the pin edge. A byte fetched for reading reaches the output pin one cycle later again. The bench holds each serial clock phase for four system clocks. It samples read data and enables just before it drops `sclk`, which is where a host would sample. It checks write strobes against a log taken on every cycle, after the frame has closed. After an abort, the enables are checked four cycles after `csb` rises, which leaves two cycles of margin.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam int SP_BYTE_W = 8;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } scp_phase_e;

  // Shift one serial bit into a byte; the order flag picks the end it enters.
  function automatic logic [SP_BYTE_W-1:0] sp_shift_in(input logic [SP_BYTE_W-1:0] sr,
                                                      input logic b, input logic lsb);
    return lsb ? {b, sr[SP_BYTE_W-1:1]} : {sr[SP_BYTE_W-2:0], b};
  endfunction

  // Advance a byte being sent: the bit on the output end is discarded.
  function automatic logic [SP_BYTE_W-1:0] sp_shift_out(input logic [SP_BYTE_W-1:0] sr,
                                                       input logic lsb);
    return lsb ? {1'b0, sr[SP_BYTE_W-1:1]} : {sr[SP_BYTE_W-2:0], 1'b0};
  endfunction

  // Bit currently on the wire for a byte being sent.
  function automatic logic sp_out_bit(input logic [SP_BYTE_W-1:0] sr, input logic lsb);
    return lsb ? sr[0] : sr[SP_BYTE_W-1];
  endfunction

endpackage

// File: rtl/scp_sync_edge.sv
module scp_sync_edge #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic csb_i,
  input  logic sdi_i,
  output logic sclk_rise,
  output logic csb_q,
  output logic sdi_q
);
  // each stage holds {sclk, csb, sdi}
  logic [STAGES-1:0][2:0] stg;
  logic                   sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= 3'b010;
      sclk_d <= 1'b0;
    end else begin
      stg[0] <= {sclk_i, csb_i, sdi_i};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sclk_d <= stg[STAGES-1][2];
    end
  end

  assign sclk_rise = stg[STAGES-1][2] & ~sclk_d;
  assign csb_q     = stg[STAGES-1][1];
  assign sdi_q     = stg[STAGES-1][0];

  // R8: a detected rising edge can never repeat on the next cycle
  rise_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/scp_addr_gen.sv
module scp_addr_gen #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic              dir_up,
  output logic [ADDR_W-1:0] addr
);
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a, input logic up);
    return up ? a + 1'b1 : a - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else if (step) addr <= next_addr(addr, dir_up);
  end

  // R11
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load || step) |=> $stable(addr));
endmodule

// File: rtl/scp_regport.sv
module scp_regport #(
  parameter int ADDR_W      = 13,
  parameter int CNT_W       = 2,
  parameter int SYNC_STAGES = 1,
  parameter int MODE_ADDR   = 0,
  parameter int LSB_BIT     = 6,
  parameter int BIDIR_BIT   = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              csb,
  input  logic              sdio_in,
  output logic              sdio_out,
  output logic              sdio_oe,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              buf_wr_en,
  output logic [ADDR_W-1:0] buf_wr_addr,
  output logic [7:0]        buf_wr_data,
  output logic [ADDR_W-1:0] buf_rd_addr,
  input  logic [7:0]        buf_rd_data
);
  import scp_pkg::*;

  localparam int              CMD_W    = 1 + CNT_W + ADDR_W;
  localparam int              BC_W     = $clog2(CMD_W);
  localparam logic [BC_W-1:0] CMD_LAST = BC_W'(CMD_W - 1);
  localparam logic [BC_W-1:0] BIT_LAST = BC_W'(SP_BYTE_W - 1);

  function automatic logic [CMD_W-1:0] cmd_shift(input logic [CMD_W-1:0] sr,
                                                 input logic b, input logic lsb);
    return lsb ? {b, sr[CMD_W-1:1]} : {sr[CMD_W-2:0], b};
  endfunction

  // synchronized pins and edge events
  logic sclk_rise, csb_q, sdi_q;

  scp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csb_i(csb), .sdi_i(sdio_in),
    .sclk_rise(sclk_rise), .csb_q(csb_q), .sdi_q(sdi_q)
  );

  scp_phase_e            phase;
  logic [BC_W-1:0]       bit_cnt;
  logic [CNT_W-1:0]      byte_idx, cnt_q;
  logic                  rd_q, fetch_q, drv_en_q, lsb_q, bidir_q;
  logic [CMD_W-1:0]      cmd_sr;
  logic [SP_BYTE_W-1:0]  in_sr, out_sr;
  logic [ADDR_W-1:0]     addr_q;

  // named internal events
  logic [CMD_W-1:0]      cmd_nxt;
  logic [SP_BYTE_W-1:0]  in_nxt;
  logic                  cmd_done, byte_done, last_byte, rd_shift, mode_hit;
  logic                  cmd_rd;
  logic [CNT_W-1:0]      cmd_cnt;
  logic [ADDR_W-1:0]     cmd_addr;

  assign cmd_nxt   = cmd_shift(cmd_sr, sdi_q, lsb_q);
  assign in_nxt    = sp_shift_in(in_sr, sdi_q, lsb_q);
  assign cmd_rd    = cmd_nxt[CMD_W-1];
  assign cmd_cnt   = cmd_nxt[CMD_W-2 -: CNT_W];
  assign cmd_addr  = cmd_nxt[ADDR_W-1:0];
  assign cmd_done  = !csb_q && sclk_rise && (phase == PH_CMD) && (bit_cnt == CMD_LAST);
  assign byte_done = !csb_q && sclk_rise && (phase == PH_DATA) && (bit_cnt == BIT_LAST);
  assign rd_shift  = !csb_q && sclk_rise && (phase == PH_DATA) && rd_q && (bit_cnt != BIT_LAST);
  assign last_byte = (byte_idx == cnt_q);
  assign mode_hit  = (addr_q == ADDR_W'(MODE_ADDR));

  scp_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(cmd_done), .load_addr(cmd_addr),
    .step(byte_done), .dir_up(lsb_q), .addr(addr_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_CMD;
      bit_cnt     <= '0;
      byte_idx    <= '0;
      cnt_q       <= '0;
      rd_q        <= 1'b0;
      fetch_q     <= 1'b0;
      drv_en_q    <= 1'b0;
      lsb_q       <= 1'b0;
      bidir_q     <= 1'b0;
      cmd_sr      <= '0;
      in_sr       <= '0;
      out_sr      <= '0;
      buf_wr_en   <= 1'b0;
      buf_wr_addr <= '0;
      buf_wr_data <= '0;
    end else if (csb_q) begin
      phase     <= PH_CMD;
      bit_cnt   <= '0;
      byte_idx  <= '0;
      fetch_q   <= 1'b0;
      drv_en_q  <= 1'b0;
      buf_wr_en <= 1'b0;
    end else begin
      buf_wr_en <= 1'b0;
      fetch_q   <= 1'b0;
      if (fetch_q) out_sr <= buf_rd_data;
      if (sclk_rise) begin
        if (phase == PH_CMD) begin
          cmd_sr <= cmd_nxt;
          if (cmd_done) begin
            phase    <= PH_DATA;
            bit_cnt  <= '0;
            byte_idx <= '0;
            cnt_q    <= cmd_cnt;
            rd_q     <= cmd_rd;
            fetch_q  <= cmd_rd;
            drv_en_q <= cmd_rd;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else begin
          in_sr <= in_nxt;
          if (byte_done) begin
            bit_cnt <= '0;
            if (!rd_q) begin
              buf_wr_en   <= 1'b1;
              buf_wr_addr <= addr_q;
              buf_wr_data <= in_nxt;
              if (mode_hit) begin
                lsb_q   <= in_nxt[LSB_BIT];
                bidir_q <= in_nxt[BIDIR_BIT];
              end
            end
            if (last_byte) begin
              phase    <= PH_CMD;
              drv_en_q <= 1'b0;
            end else begin
              byte_idx <= byte_idx + 1'b1;
              fetch_q  <= rd_q;
            end
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            if (rd_q) out_sr <= sp_shift_out(out_sr, lsb_q);
          end
        end
      end
    end
  end

  assign buf_rd_addr = addr_q;
  assign sdo         = sp_out_bit(out_sr, lsb_q);
  assign sdio_out    = sdo;
  assign sdo_oe      = drv_en_q & ~bidir_q;
  assign sdio_oe     = drv_en_q & bidir_q;

  // R10
  csb_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csb_q |=> (phase == PH_CMD) && !sdo_oe && !sdio_oe);

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |=> !buf_wr_en);

  // R3
  byte_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> (byte_idx <= cnt_q));

  // R8
  rd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_shift || fetch_q) |=> $stable(out_sr));

  // R9
  oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_oe && sdio_oe));
endmodule

// File: tb/scp_regport_tb_top.sv
module scp_regport_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HP         = 4;

  logic        clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csb = 1'b1, sdio_in = 1'b0;
  logic        sdio_out, sdio_oe, sdo, sdo_oe, buf_wr_en;
  logic [12:0] buf_wr_addr, buf_rd_addr;
  logic [7:0]  buf_wr_data, buf_rd_data;

  logic [7:0]  mem [128];
  logic [12:0] log_a [256];
  logic [7:0]  log_d [256];
  int          log_n = 0;
  int          checks = 0, fails = 0;
  logic        lsb_m = 1'b0, bidir_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scp_regport dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csb(csb), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe),
    .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
    .buf_rd_addr(buf_rd_addr), .buf_rd_data(buf_rd_data)
  );

  assign buf_rd_data = mem[buf_rd_addr[6:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'((i * 37 + 5) & 8'hFE);
    end else if (buf_wr_en) begin
      mem[buf_wr_addr[6:0]] <= buf_wr_data;
      log_a[log_n[7:0]] <= buf_wr_addr;
      log_d[log_n[7:0]] <= buf_wr_data;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [12:0] step_n(input logic [12:0] a, input int k, input logic up);
    return up ? 13'(a + 13'(k)) : 13'(a - 13'(k));
  endfunction

  task automatic sbit(input logic b, output logic smp, output logic ou, output logic ob);
    sdio_in = b;
    repeat (HP) @(negedge clk);
    sclk = 1'b1;
    repeat (HP) @(negedge clk);
    smp = bidir_m ? sdio_out : sdo;
    ou  = sdo_oe;
    ob  = sdio_oe;
    sclk = 1'b0;
  endtask

  // One framed access; abort_bits > 0 raises csb after that many bits.
  task automatic frame(input logic rw, input int nb, input logic [12:0] a,
                       input logic [31:0] wd, input int abort_bits,
                       output logic [31:0] rd, output int ou_n, output int ob_n);
    logic [15:0] cmd;
    logic [7:0]  byt;
    logic        b, s, ou, ob;
    int          total;
    cmd   = {rw, 2'(nb - 1), a};
    total = (abort_bits > 0) ? abort_bits : 16 + 8 * nb;
    rd = '0; ou_n = 0; ob_n = 0;
    csb = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < total; i++) begin
      if (i < 16) b = lsb_m ? cmd[i] : cmd[15 - i];
      else begin
        byt = wd[8 * ((i - 16) / 8) +: 8];
        b = lsb_m ? byt[(i - 16) % 8] : byt[7 - (i - 16) % 8];
      end
      sbit(b, s, ou, ob);
      if (i >= 15 && i < 15 + 8 * nb) begin
        rd[8 * ((i - 15) / 8) + (lsb_m ? (i - 15) % 8 : 7 - (i - 15) % 8)] = s;
        ou_n += int'(ou);
        ob_n += int'(ob);
      end
    end
    csb = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input string tag, input int nb, input logic [12:0] a, input logic [31:0] wd);
    logic [31:0] rd;
    int ou_n, ob_n, base;
    base = log_n;
    frame(1'b0, nb, a, wd, 0, rd, ou_n, ob_n);
    chk({tag, " write count"}, 32'(log_n - base), 32'(nb));
    chk({tag, " no drive on write"}, 32'(ou_n + ob_n), 0);
    for (int k = 0; k < nb; k++) begin
      chk({tag, " write addr"}, 32'(log_a[8'(base + k)]), 32'(step_n(a, k, lsb_m)));
      chk({tag, " write data"}, 32'(log_d[8'(base + k)]), 32'(wd[8 * k +: 8]));
    end
  endtask

  task automatic do_read(input string tag, input int nb, input logic [12:0] a);
    logic [31:0] rd, exp;
    int ou_n, ob_n;
    exp = '0;
    for (int k = 0; k < nb; k++) exp[8 * k +: 8] = mem[step_n(a, k, lsb_m) & 13'h7F];
    frame(1'b1, nb, a, 32'h0, 0, rd, ou_n, ob_n);
    chk({tag, " read data"}, rd, exp);
    chk({tag, " sdo_oe bits"}, 32'(ou_n), bidir_m ? 0 : 32'(8 * nb));
    chk({tag, " sdio_oe bits"}, 32'(ob_n), bidir_m ? 32'(8 * nb) : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    logic [31:0] rd, wd;
    int ou_n, ob_n, base;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 sdo_oe", 32'(sdo_oe), 0);
    chk("R1 sdio_oe", 32'(sdio_oe), 0);
    chk("R1 wr_en", 32'(buf_wr_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R5 R4: MSB-first four-byte write, address decrements
    do_write("R2 R5 R4 msb4", 4, 13'h13, 32'hA1B2C3D4);
    // R3 count code sweep
    for (int nb = 1; nb <= 4; nb++) do_write("R3 count", nb, 13'h48, 32'h5E6F7081 ^ 32'(nb * 1111));
    // R8 R9 R11 MSB read over the bytes just written
    do_read("R8 R9 R11 msb3", 3, 13'h12);
    chk("R8 first byte", 32'(mem[7'h12]), 32'hC3);
    // R5 wrap 0000h -> 1FFFh (byte for 0000h keeps the mode bits clear)
    do_write("R5 wrap", 2, 13'h0000, 32'h00005A00);

    // R10 abort mid-byte of a write
    base = log_n;
    wd = {24'h0, mem[7'h30]};
    frame(1'b0, 1, 13'h30, 32'hFF, 16 + 5, rd, ou_n, ob_n);
    chk("R10 no partial write", 32'(log_n - base), 0);
    chk("R10 buffer kept", 32'(mem[7'h30]), wd);
    do_write("R10 next frame", 1, 13'h30, 32'h3C);
    // R10 abort in a read
    frame(1'b1, 2, 13'h10, 32'h0, 16 + 4, rd, ou_n, ob_n);
    chk("R10 sdo_oe dropped", 32'(sdo_oe), 0);
    chk("R10 sdio_oe dropped", 32'(sdio_oe), 0);
    do_read("R10 read after abort", 1, 13'h11);

    // R7 switch to LSB-first
    do_write("R7 mode set", 1, 13'h0000, 32'h40);
    lsb_m = 1'b1;
    // R6 LSB-first write/read, address increments
    do_write("R6 lsb3", 3, 13'h20, 32'h0096E1C3);
    do_read("R6 R8 lsb read", 3, 13'h20);
    do_write("R6 wrap", 2, 13'h1FFF, 32'h00004077);
    // R7 R9 bidirectional
    do_write("R7 bidir set", 1, 13'h0000, 32'hC0);
    bidir_m = 1'b1;
    do_read("R9 bidir read", 2, 13'h21);
    do_write("R7 mode clear", 1, 13'h0000, 32'h00);
    lsb_m = 1'b0; bidir_m = 1'b0;
    do_read("R9 R5 back to msb", 1, 13'h22);

    // R3 R5 R11 sweep: write then read back in MSB-first mode
    foreach (mem[i]) if (i < 0) chk("unused", 0, 0);
    for (int bi = 0; bi < 3; bi++) begin
      for (int nb = 1; nb <= 4; nb++) begin
        logic [12:0] a;
        a  = (bi == 0) ? 13'h05 : (bi == 1) ? 13'h33 : 13'h7C;
        wd = 32'(int'(a) * 97 + nb * 13) ^ 32'h5A3C96E1;
        do_write("R3 sweep", nb, a, wd);
        do_read("R11 sweep", nb, a);
        chk("R11 sweep echo", 32'(mem[step_n(a, nb - 1, 1'b0) & 13'h7F]), 32'(wd[8 * (nb - 1) +: 8]));
      end
    end
    summary();
  end
endmodule